// File: doc/BRIEF.md
# Rotating Priority Interrupt Resolver

This block decides, for an eight-input interrupt controller, whether a request should be raised to the processor and which input wins. It receives the pending-request vector, the mask vector, the in-service vector, a rotation offset and three mode flags, all as plain input ports. Register programming, acknowledge handling and vector formation belong to the surrounding controller.

A candidate is any input that is requesting and not masked. Candidates are ranked by a rotating priority: the offset names the input with the highest priority, and priority falls with increasing input number, wrapping past the top. In-service inputs are ranked the same way. The interrupt is raised only when the best candidate ranks strictly above the best in-service input. Two modes change which in-service bits count. On the primary controller, special fully nested mode ignores the cascade input's in-service bit when the cascade input is the winner. Special mask mode drops the in-service bits of masked inputs.

Both results are registered, so they follow the inputs one clock later.

Top module: `irq_prio_resolver`

## Requirements
- R1: While `rst_n` is low, `irq_out` is 0 and `win_id` is 0.
- R2: When no input has its request bit set and its mask bit clear, `irq_out` is 0 one clock later.
- R3: The winner is the first candidate found when scanning input numbers `rot_ofs`, `rot_ofs`+1, ... modulo 8. With no in-service bits, `irq_out` is 1 and `win_id` holds that input number.
- R4: An in-service input blocks the winner when it comes at or before the winner in the same rotated scan. An in-service bit on the winner itself blocks it. An in-service bit scanned after the winner does not.
- R5: When `is_primary`=1 and `sfn_mode`=1, the in-service bit of input 2 (the cascade input) is ignored if input 2 is the winner. With either flag at 0 it counts normally.
- R6: When `smm_mode`=1, in-service bits of inputs whose mask bit is 1 are ignored. When `smm_mode`=0 they count.
- R7: `irq_out` and `win_id` reflect the inputs sampled at the previous rising clock edge. A change on any input is visible after exactly one edge and not before.
- R8: Whenever `irq_out` is 0, `win_id` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_vec | input | 8 | Pending request bits, one per input |
| mask_vec | input | 8 | Mask bits; 1 masks the input |
| insvc_vec | input | 8 | In-service bits |
| rot_ofs | input | 3 | Input number holding the highest priority |
| is_primary | input | 1 | 1 when this controller is the primary in a cascade |
| sfn_mode | input | 1 | Special fully nested mode enable |
| smm_mode | input | 1 | Special mask mode enable |
| irq_out | output | 1 | Registered interrupt request |
| win_id | output | 3 | Registered winning input number, 0 when idle |

## Verification
The assertions assume that `rot_ofs` is smaller than the input count and that the input count is a power of two. At the default size, every 3-bit offset is legal. They also assume that the inputs seen at one clock edge are the ones the registered outputs answer at the next. The bench meets this by changing inputs only on the falling edge and holding them across the following rising edge. It drives every offset and all three mode flags, and it also drives in-service patterns that real acknowledge sequencing would never produce. The resolver has to stay consistent even for those patterns.

// File: rtl/irqr_pkg.sv
package irqr_pkg;
  typedef struct packed {
    logic primary;
    logic sfn;
    logic smm;
  } irqr_mode_t;
endpackage

// File: rtl/irqr_rot_search.sv
module irqr_rot_search #(
  parameter int N = 8,
  localparam int W = $clog2(N),
  localparam int PW = W + 1
) (
  input  logic [N-1:0]  vec,
  input  logic [W-1:0]  ofs,
  output logic [PW-1:0] prio,
  output logic [W-1:0]  idx
);
  function automatic logic [N-1:0] rot_right(input logic [N-1:0] v, input logic [W-1:0] o);
    logic [N-1:0] r;
    logic [W-1:0] j;
    for (int i = 0; i < N; i++) begin
      j = W'(i) + o;
      r[i] = v[j];
    end
    return r;
  endfunction

  function automatic logic [PW-1:0] lowest_set(input logic [N-1:0] v);
    logic [PW-1:0] r;
    r = PW'(N);
    for (int i = N - 1; i >= 0; i--) begin
      if (v[i]) r = PW'(i);
    end
    return r;
  endfunction

  logic [N-1:0] rotated;

  always_comb begin
    rotated = rot_right(vec, ofs);
    prio    = lowest_set(rotated);
    idx     = prio[W-1:0] + ofs;
  end
endmodule

// File: rtl/irqr_svc_filter.sv
module irqr_svc_filter #(
  parameter int N = 8,
  parameter int CASC = 2,
  localparam int W = $clog2(N)
) (
  input  logic [N-1:0]        insvc,
  input  logic [N-1:0]        mask,
  input  logic [W-1:0]        win_idx,
  input  logic                win_any,
  input  irqr_pkg::irqr_mode_t mode,
  output logic [N-1:0]        svc_eff,
  output logic                casc_skip
);
  always_comb begin
    casc_skip = mode.primary && mode.sfn && win_any && (win_idx == W'(CASC));
    svc_eff   = insvc;
    if (casc_skip) svc_eff[CASC] = 1'b0;
    if (mode.smm)  svc_eff = svc_eff & ~mask;
  end
endmodule

// File: rtl/irq_prio_resolver.sv
module irq_prio_resolver #(
  parameter int N = 8,
  parameter int CASC = 2,
  localparam int W = $clog2(N),
  localparam int PW = W + 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req_vec,
  input  logic [N-1:0] mask_vec,
  input  logic [N-1:0] insvc_vec,
  input  logic [W-1:0] rot_ofs,
  input  logic         is_primary,
  input  logic         sfn_mode,
  input  logic         smm_mode,
  output logic         irq_out,
  output logic [W-1:0] win_id
);
  localparam logic [PW-1:0] PRIO_NONE = PW'(N);

  irqr_pkg::irqr_mode_t mode;
  logic [N-1:0]  cand_vec;
  logic [PW-1:0] cand_prio;
  logic [W-1:0]  cand_idx;
  logic          cand_any;
  logic [N-1:0]  svc_eff;
  logic          casc_skip;
  logic [PW-1:0] svc_prio;
  logic [W-1:0]  svc_idx;
  logic          fire;

  always_comb begin
    mode.primary = is_primary;
    mode.sfn     = sfn_mode;
    mode.smm     = smm_mode;
    cand_vec     = req_vec & ~mask_vec;
    cand_any     = (cand_prio != PRIO_NONE);
  end

  irqr_rot_search #(.N(N)) u_cand (
    .vec(cand_vec), .ofs(rot_ofs), .prio(cand_prio), .idx(cand_idx)
  );

  irqr_svc_filter #(.N(N), .CASC(CASC)) u_filt (
    .insvc(insvc_vec), .mask(mask_vec), .win_idx(cand_idx), .win_any(cand_any),
    .mode(mode), .svc_eff(svc_eff), .casc_skip(casc_skip)
  );

  irqr_rot_search #(.N(N)) u_svc (
    .vec(svc_eff), .ofs(rot_ofs), .prio(svc_prio), .idx(svc_idx)
  );

  assign fire = cand_any && (cand_prio < svc_prio);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_out <= 1'b0;
      win_id  <= '0;
    end else begin
      irq_out <= fire;
      win_id  <= fire ? cand_idx : '0;
    end
  end

  // R2: an empty candidate set must be reported as "none" by the search
  a_r2_none_iff_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (cand_prio == PRIO_NONE) == (cand_vec == '0));

  // R2: a raised request needs a candidate in the previous cycle
  a_r2_needs_candidate: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> ($past(cand_vec) != '0));

  // R3: the reported winner was a candidate
  a_r3_winner_is_candidate: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> ((($past(cand_vec) >> win_id) & N'(1)) != '0));

  // R4: the reported winner was not among the counted in-service bits
  a_r4_winner_not_in_service: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> ((($past(svc_eff) >> win_id) & N'(1)) == '0));

  // R5: the cascade bit is only skipped when its flags are set
  a_r5_skip_needs_flags: assert property (@(posedge clk) disable iff (!rst_n)
    casc_skip |-> (is_primary && sfn_mode && cand_idx == W'(CASC)));

  // R8: idle output carries a zero id
  a_r8_idle_id_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_out |-> (win_id == '0));

  // R1: reset holds both outputs at zero
  always_comb begin
    if (!rst_n) a_r1_reset_zero: assert (!irq_out && win_id == '0);
  end
endmodule

// File: tb/irq_prio_resolver_tb.sv
module irq_prio_resolver_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] req_vec = '0, mask_vec = '0, insvc_vec = '0;
  logic [2:0] rot_ofs = '0;
  logic is_primary = 1'b0, sfn_mode = 1'b0, smm_mode = 1'b0;
  logic irq_out;
  logic [2:0] win_id;

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_prio_resolver u_dut (
    .clk(clk), .rst_n(rst_n), .req_vec(req_vec), .mask_vec(mask_vec),
    .insvc_vec(insvc_vec), .rot_ofs(rot_ofs), .is_primary(is_primary),
    .sfn_mode(sfn_mode), .smm_mode(smm_mode), .irq_out(irq_out), .win_id(win_id)
  );

  // Reference: walk the inputs in scan order and rank them by position.
  function automatic logic [3:0] model(input logic [7:0] rq, input logic [7:0] mk,
                                       input logic [7:0] sv, input logic [2:0] of,
                                       input logic pr, input logic sf, input logic sm);
    int win_pos = 8, win_num = 0, svc_pos = 8;
    logic [7:0] svc;
    for (int k = 0; k < 8; k++) begin
      int n = (of + k) % 8;
      if (win_pos == 8 && rq[n] && !mk[n]) begin win_pos = k; win_num = n; end
    end
    svc = sv;
    if (pr && sf && win_pos < 8 && win_num == 2) svc[2] = 1'b0;
    if (sm) svc = svc & ~mk;
    for (int k = 7; k >= 0; k--) if (svc[(of + k) % 8]) svc_pos = k;
    if (win_pos < svc_pos) return {1'b1, 3'(win_num)};
    return 4'b0000;
  endfunction

  task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: irq/id actual=%b/%0d expected=%b/%0d", tag, act[3], act[2:0], exp[3], exp[2:0]);
    end
  endtask

  task automatic apply(input logic [7:0] rq, input logic [7:0] mk, input logic [7:0] sv,
                       input logic [2:0] of, input logic pr, input logic sf, input logic sm);
    @(negedge clk);
    req_vec = rq; mask_vec = mk; insvc_vec = sv; rot_ofs = of;
    is_primary = pr; sfn_mode = sf; smm_mode = sm;
    @(posedge clk); #1;
  endtask

  task automatic run_case(input string tag, input logic [7:0] rq, input logic [7:0] mk,
                          input logic [7:0] sv, input logic [2:0] of,
                          input logic pr, input logic sf, input logic sm);
    apply(rq, mk, sv, of, pr, sf, sm);
    check(tag, {irq_out, win_id}, model(rq, mk, sv, of, pr, sf, sm));
  endtask

  task automatic t_reset;
    #2;
    check("R1 reset", {irq_out, win_id}, 4'b0000);
    @(negedge clk); req_vec = 8'hFF;
    @(posedge clk); #1;
    check("R1 reset held", {irq_out, win_id}, 4'b0000);
    @(negedge clk); req_vec = '0; rst_n = 1'b1;
  endtask

  task automatic t_no_cand;
    run_case("R2 no request", 8'h00, 8'h00, 8'h00, 3'd0, 0, 0, 0);
    run_case("R2 all masked", 8'hFF, 8'hFF, 8'h00, 3'd5, 0, 0, 0);
    check("R2 all masked value", {irq_out, win_id}, 4'b0000);
    check("R8 idle id", {1'b0, win_id}, 4'b0000);
  endtask

  task automatic t_rotation;
    logic [7:0] pats [5] = '{8'h81, 8'h24, 8'hFF, 8'h10, 8'h5A};
    run_case("R3 fixed", 8'h81, 8'h00, 8'h00, 3'd1, 0, 0, 0);
    check("R3 wrap to 7", {irq_out, win_id}, 4'b1111);
    for (int p = 0; p < 5; p++)
      for (int o = 0; o < 8; o++)
        run_case("R3 sweep", pats[p], 8'h00, 8'h00, 3'(o), 0, 0, 0);
  endtask

  task automatic t_nesting;
    run_case("R4 equal blocks", 8'h08, 8'h00, 8'h08, 3'd0, 0, 0, 0);
    check("R4 equal value", {irq_out, win_id}, 4'b0000);
    run_case("R4 higher fires", 8'h04, 8'h00, 8'h08, 3'd0, 0, 0, 0);
    check("R4 higher value", {irq_out, win_id}, 4'b1010);
    run_case("R4 lower blocked", 8'h10, 8'h00, 8'h08, 3'd0, 0, 0, 0);
    run_case("R4 rotated fires", 8'h10, 8'h00, 8'h08, 3'd4, 0, 0, 0);
    check("R4 rotated value", {irq_out, win_id}, 4'b1100);
  endtask

  task automatic t_sfn;
    run_case("R5 sfn cascade", 8'h04, 8'h00, 8'h04, 3'd0, 1, 1, 0);
    check("R5 sfn value", {irq_out, win_id}, 4'b1010);
    run_case("R5 sfn off", 8'h04, 8'h00, 8'h04, 3'd0, 1, 0, 0);
    check("R5 sfn off value", {irq_out, win_id}, 4'b0000);
    run_case("R5 secondary", 8'h04, 8'h00, 8'h04, 3'd0, 0, 1, 0);
    check("R5 secondary value", {irq_out, win_id}, 4'b0000);
    run_case("R5 other winner", 8'h08, 8'h00, 8'h04, 3'd0, 1, 1, 0);
    check("R5 other value", {irq_out, win_id}, 4'b0000);
  endtask

  task automatic t_smm;
    run_case("R6 smm off", 8'h10, 8'h01, 8'h01, 3'd0, 0, 0, 0);
    check("R6 smm off value", {irq_out, win_id}, 4'b0000);
    run_case("R6 smm on", 8'h10, 8'h01, 8'h01, 3'd0, 0, 0, 1);
    check("R6 smm on value", {irq_out, win_id}, 4'b1100);
    run_case("R6 unmasked svc", 8'h10, 8'h00, 8'h01, 3'd0, 0, 0, 1);
    check("R6 unmasked value", {irq_out, win_id}, 4'b0000);
  endtask

  task automatic t_latency;
    apply(8'h00, 8'h00, 8'h00, 3'd0, 0, 0, 0);
    @(negedge clk); req_vec = 8'h40; #1;
    check("R7 before edge", {irq_out, win_id}, 4'b0000);
    @(posedge clk); #1;
    check("R7 after edge", {irq_out, win_id}, 4'b1110);
    @(negedge clk); mask_vec = 8'h40; #1;
    check("R7 hold", {irq_out, win_id}, 4'b1110);
    @(posedge clk); #1;
    check("R7 drop", {irq_out, win_id}, 4'b0000);
  endtask

  task automatic t_mixed;
    logic [31:0] s = 32'h1234_5678;
    for (int i = 0; i < 300; i++) begin
      s = s ^ (s << 13); s = s ^ (s >> 17); s = s ^ (s << 5);
      run_case("R3/R4/R5/R6 mixed", s[7:0], s[15:8] & s[31:24], s[23:16] & {s[2:0], s[7:3]},
               s[26:24], s[27], s[28], s[29]);
      if (!irq_out) check("R8 idle id", {1'b0, win_id}, 4'b0000);
    end
  endtask

  initial begin
    t_reset();
    t_no_cand();
    t_rotation();
    t_nesting();
    t_sfn();
    t_smm();
    t_latency();
    t_mixed();
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_checks++; n_errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end
endmodule